// File: doc/BRIEF.md
# Three-Tap Streaming FIR Filter

This block filters a stream of 12-bit unsigned samples with a three-tap finite impulse response. Each accepted sample is combined with the two samples accepted before it. Each of the three is multiplied by its own weight, and the three products are added. The result is captured in an output register and offered downstream. The low 12 bits are the filtered sample, and the full-precision sum is available beside it for checking.

The three weights live in internal registers. They are written one at a time: a write strobe, a 2-bit select and a shared 12-bit data word are decoded into per-register enables. There is no sequencing controller. The block is a pure datapath wrapped in a valid/ready stream on each side.

Back-pressure rules: the input side is ready whenever the output register is empty or is being drained in the same cycle. A sample moves in only on a cycle where valid and ready are both high. While the output is valid and not taken, the output holds its value and the input is stalled.

Top module: `fir3_stream`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the output register (m_valid 0, m_full 0), both history registers and all three weights. A sample sent right after reset therefore yields 0.
- R2: For a sample accepted at an edge, m_full equals w0*x(n) + w1*x(n-1) + w2*x(n-2). Here x(n-1) and x(n-2) are the two previously accepted samples, and all values are unsigned. The 26-bit sum is never truncated.
- R3: m_data always equals bits 11:0 of m_full, which is plain truncation with no saturation.
- R4: The history advances only on accepted samples. Cycles with s_valid low, or with s_ready low, leave the history unchanged.
- R5: A sample accepted at an edge gives m_valid 1 and its result on m_full/m_data right after that same edge. A cycle with no acceptance and no output pending leaves m_valid 0.
- R6: While m_valid is 1 and m_ready is 0, m_data and m_full hold their values and m_valid stays 1.
- R7: s_ready is 0 while m_valid is 1 and m_ready is 0. Otherwise s_ready is 1.
- R8: A write with coef_wr 1 loads coef_data into weight w0, w1 or w2 for coef_addr 0, 1 or 2. The new weight first applies to samples accepted at later edges. A sample accepted at the same edge as the write uses the old weight.
- R9: A write with coef_addr 3 changes no weight.
- R10: When the output is taken (m_valid and m_ready both 1) and no new sample is accepted, m_valid is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample is valid |
| s_ready | output | 1 | Block can accept a sample this cycle |
| s_data | input | 12 | Input sample, unsigned |
| m_valid | output | 1 | Output register holds a result |
| m_ready | input | 1 | Downstream takes the result this cycle |
| m_data | output | 12 | Filtered sample, low 12 bits of the sum |
| m_full | output | 26 | Full-precision weighted sum |
| coef_wr | input | 1 | Weight write strobe |
| coef_addr | input | 2 | Weight select: 0, 1, 2 pick w0..w2, 3 is unused |
| coef_data | input | 12 | Weight value to write, unsigned |

## Verification
Every result is due exactly one register stage after its sample is accepted. It is visible right after the accepting edge. A weight write is visible only in results of samples accepted at a later edge. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check reads the state that settled after the one edge in question. For stall and idle cycles, the bench samples again on each falling edge. It compares against values held over from before, or against a model whose history it has not advanced.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int NTAPS  = 3;
  localparam int ADDR_W = 2;

  // weight select codes on the write port
  typedef enum logic [ADDR_W-1:0] {
    SEL_W0   = 2'd0,
    SEL_W1   = 2'd1,
    SEL_W2   = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/fir3_wbank.sv
module fir3_wbank
  import fir3_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CW-1:0]         data,
  output logic [NTAPS*CW-1:0]   weights
);
  logic [NTAPS-1:0] en;

  // decoder: one enable per weight, gated by the strobe
  always_comb begin
    en = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (wr && (addr == ADDR_W'(i))) en[i] = 1'b1;
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_w
    logic [CW-1:0] w_q;
    always_ff @(posedge clk) begin
      if (rst)        w_q <= '0;
      else if (en[g]) w_q <= data;
    end
    assign weights[g*CW +: CW] = w_q;
  end
endmodule

// File: rtl/fir3_history.sv
module fir3_history
  import fir3_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shift,
  input  logic [DW-1:0]             din,
  output logic [(NTAPS-1)*DW-1:0]   hist
);
  localparam int DEPTH = NTAPS - 1;

  // stage 0 holds x(n-1), stage k holds x(n-1-k)
  for (genvar g = 0; g < DEPTH; g++) begin : g_st
    logic [DW-1:0] s_q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)        s_q <= '0;
        else if (shift) s_q <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)        s_q <= '0;
        else if (shift) s_q <= g_st[g-1].s_q;
      end
    end
    assign hist[g*DW +: DW] = s_q;
  end
endmodule

// File: rtl/fir3_mac.sv
module fir3_mac
  import fir3_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12,
  parameter int SW = 26
) (
  input  logic [DW-1:0]             cur,
  input  logic [(NTAPS-1)*DW-1:0]   hist,
  input  logic [NTAPS*CW-1:0]       weights,
  output logic [SW-1:0]             sum
);
  logic [SW-1:0] prod [NTAPS];
  logic [SW-1:0] part [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    logic [DW-1:0] xv;
    if (g == 0) begin : g_cur
      assign xv = cur;
    end else begin : g_old
      assign xv = hist[(g-1)*DW +: DW];
    end
    assign prod[g] = SW'(xv) * SW'(weights[g*CW +: CW]);

    // adder chain: running sum through the taps
    if (g == 0) begin : g_first
      assign part[g] = prod[g];
    end else begin : g_add
      assign part[g] = part[g-1] + prod[g];
    end
  end

  assign sum = part[NTAPS-1];
endmodule

// File: rtl/fir3_stream.sv
module fir3_stream
  import fir3_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int SUM_W    = SAMPLE_W + COEF_W + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [SAMPLE_W-1:0]  s_data,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [SAMPLE_W-1:0]  m_data,
  output logic [SUM_W-1:0]     m_full,
  input  logic                 coef_wr,
  input  logic [ADDR_W-1:0]    coef_addr,
  input  logic [COEF_W-1:0]    coef_data
);
  logic                         take;
  logic [NTAPS*COEF_W-1:0]      weights;
  logic [(NTAPS-1)*SAMPLE_W-1:0] hist;
  logic [SUM_W-1:0]             sum;
  logic                         ov_q;
  logic [SUM_W-1:0]             full_q;

  assign s_ready = !ov_q || m_ready;
  assign take    = s_valid && s_ready;

  fir3_wbank #(.CW(COEF_W)) u_wbank (
    .clk     (clk),
    .rst     (rst),
    .wr      (coef_wr),
    .addr    (coef_addr),
    .data    (coef_data),
    .weights (weights)
  );

  fir3_history #(.DW(SAMPLE_W)) u_hist (
    .clk   (clk),
    .rst   (rst),
    .shift (take),
    .din   (s_data),
    .hist  (hist)
  );

  fir3_mac #(.DW(SAMPLE_W), .CW(COEF_W), .SW(SUM_W)) u_mac (
    .cur     (s_data),
    .hist    (hist),
    .weights (weights),
    .sum     (sum)
  );

  // output register: loads on acceptance, empties when taken
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q   <= 1'b0;
      full_q <= '0;
    end else if (take) begin
      ov_q   <= 1'b1;
      full_q <= sum;
    end else if (m_ready) begin
      ov_q   <= 1'b0;
    end
  end

  assign m_valid = ov_q;
  assign m_full  = full_q;
  assign m_data  = full_q[SAMPLE_W-1:0];
endmodule

// File: rtl/fir3_chk.sv
module fir3_chk #(
  parameter int SAMPLE_W = 12,
  parameter int SUM_W    = 26
) (
  input logic                clk,
  input logic                rst,
  input logic                s_valid,
  input logic                s_ready,
  input logic                m_valid,
  input logic                m_ready,
  input logic [SAMPLE_W-1:0] m_data,
  input logic [SUM_W-1:0]    m_full
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!m_valid && m_full == '0)); // R1

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_full) && $stable(m_data))); // R6

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready); // R7

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> m_valid); // R5

  AST_IDLE_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!m_valid && !s_valid) |=> !m_valid); // R5

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && !s_valid) |=> !m_valid); // R10
endmodule

bind fir3_stream fir3_chk #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_full  (m_full)
);

// File: tb/sim_fir3_stream.sv
`timescale 1ns/1ps
module sim_fir3_stream;
  localparam int NV = 6;
  localparam logic [11:0] VX   [NV] = '{12'd10, 12'd20, 12'd30, 12'd4095, 12'd0, 12'd5};
  localparam int          VFUL [NV] = '{10, 40, 100, 4215, 8280, 12290};
  localparam int          VLOW [NV] = '{10, 40, 100, 119, 88, 2};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [11:0] m_data;
  logic [25:0] m_full;
  logic        coef_wr = 1'b0;
  logic [1:0]  coef_addr = '0;
  logic [11:0] coef_data = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  longint w [3];
  longint h1, h2, expv;

  always #2.5 clk = ~clk;

  fir3_stream u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_full(m_full),
    .coef_wr(coef_wr), .coef_addr(coef_addr), .coef_data(coef_data)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; s_valid = 1'b0; coef_wr = 1'b0; m_ready = 1'b1;
    @(negedge clk); rst = 1'b0;
    w[0] = 0; w[1] = 0; w[2] = 0; h1 = 0; h2 = 0;
  endtask

  task automatic model_push(input longint x);
    expv = w[0]*x + w[1]*h1 + w[2]*h2;
    h2 = h1; h1 = x;
  endtask

  task automatic wr_w(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk); coef_wr = 1'b1; coef_addr = a; coef_data = d;
    @(negedge clk); coef_wr = 1'b0;
    if (a != 2'd3) w[a] = d;
  endtask

  // send one sample with m_ready high; result checked one edge later
  task automatic push(input logic [11:0] x, input string tag);
    @(negedge clk); s_valid = 1'b1; s_data = x; m_ready = 1'b1;
    model_push(x);
    @(negedge clk); s_valid = 1'b0;
    check({tag, " m_valid"}, m_valid, 1);
    check({tag, " m_full"}, m_full, expv);
    check({tag, " m_data"}, m_data, expv & 12'hFFF);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state, then zero weights give zero
    check("R1 m_valid after reset", m_valid, 0);
    check("R1 m_full after reset", m_full, 0);
    push(12'd7, "R1 zero weights");

    do_reset();
    wr_w(2'd0, 12'd1);
    wr_w(2'd1, 12'd2);
    wr_w(2'd2, 12'd3);
    wr_w(2'd3, 12'd999); // R9: no weight changes, table results prove it

    // R2 R3: table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); s_valid = 1'b1; s_data = VX[i];
      @(negedge clk); s_valid = 1'b0;
      check("R2 table m_full", m_full, VFUL[i]);
      check("R3 table m_data", m_data, VLOW[i]);
      h2 = h1; h1 = VX[i];
    end

    // R10: drained output with no new sample
    @(negedge clk);
    check("R10 m_valid after drain", m_valid, 0);
    // R4: idle cycles leave history alone
    repeat (3) @(negedge clk);
    push(12'd100, "R4 after idle");

    // R2 R3: largest operands
    wr_w(2'd0, 12'd4095); wr_w(2'd1, 12'd4095); wr_w(2'd2, 12'd4095);
    push(12'd4095, "R2 max a");
    push(12'd4095, "R2 max b");
    push(12'd4095, "R2 max c");
    check("R2 max full", m_full, 64'd50307075);
    check("R3 max low", m_data, 3);

    // R8: write at the same edge as a sample uses old weight
    wr_w(2'd0, 12'd1); wr_w(2'd1, 12'd0); wr_w(2'd2, 12'd0);
    @(negedge clk); s_valid = 1'b1; s_data = 12'd50;
    coef_wr = 1'b1; coef_addr = 2'd0; coef_data = 12'd9;
    model_push(50);
    @(negedge clk); s_valid = 1'b0; coef_wr = 1'b0; w[0] = 9;
    check("R8 same-edge write old weight", m_full, expv);
    push(12'd50, "R8 new weight");
    check("R8 new weight value", m_full, 450);
    wr_w(2'd1, 12'd2);
    push(12'd1, "R8 w1 select");
    check("R8 w1 value", m_full, 9 + 100);

    // R9: address 3 alone, then sample shows same weights
    wr_w(2'd3, 12'd4000);
    push(12'd3, "R9 addr3 ignored");

    // R6 R7: back-pressure
    @(negedge clk); m_ready = 1'b0; s_valid = 1'b1; s_data = 12'd11;
    model_push(11);
    begin
      longint held;
      held = expv;
      @(negedge clk); s_data = 12'd22;
      check("R6 stalled valid", m_valid, 1);
      check("R6 stalled value", m_full, held);
      check("R7 s_ready low", s_ready, 0);
      repeat (2) begin
        @(negedge clk);
        check("R6 hold", m_full, held);
        check("R7 still low", s_ready, 0);
      end
      m_ready = 1'b1;
      #0.1;
      check("R7 s_ready with m_ready", s_ready, 1);
      model_push(22); // R4: only one shift for the stalled word
      @(negedge clk); s_valid = 1'b0;
      check("R4 after stall", m_full, expv);
      @(negedge clk);
      check("R10 empty", m_valid, 0);
      check("R7 idle ready", s_ready, 1);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule